// File: doc/BRIEF.md
# Modem Status Register

This block watches the four active-low modem handshake inputs of a serial port: clear-to-send, data-set-ready, ring indicator and carrier detect. Each pin passes through a synchroniser. The block then shows the active-high level of every line and keeps a sticky change flag for each one. A single read strobe returns the 8-bit status byte in the same cycle and clears the change flags. While any change flag is set, the block requests an interrupt.

In loopback mode the pins are ignored. Four bits from the modem-control register (RTS, DTR, OUT1, OUT2) take their place as the line levels. The change detectors watch these looped-back levels, so software can exercise the flags without external wiring. Toggling loopback while a pin level differs from its loopback bit counts as a change on that line.

Top module: `modem_status_reg`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), status bits 0 to 3 read 0 from the next edge on, and msi_req is 0.
- R2: Status bit 0 sets when the clear-to-send level changes in either direction.
- R3: Status bit 1 sets when the data-set-ready level changes in either direction.
- R4: Status bit 2 sets only when the ring pin ri_n_pin goes from low to high. A high-to-low transition leaves it clear.
- R5: Status bit 3 sets when the carrier-detect level changes in either direction.
- R6: With loopback off, status bits 4, 5, 6 and 7 hold the complements of cts_n_pin, dsr_n_pin, ri_n_pin and dcd_n_pin. A pin change shows there two clock edges after it is sampled, and the matching change flag sets on the third edge.
- R7: With loop_en high, status bits 4 to 7 equal mc_rts, mc_dtr, mc_out1 and mc_out2, and the pins have no effect. A change on these bits sets the matching flag on the next edge. For the ring line, that means only mc_out1 going from 1 to 0.
- R8: status_byte is valid in the cycle where rd_stb is high. Bits 0 to 3 clear at the clock edge that ends that cycle.
- R9: A change detected at the same edge that ends a read cycle leaves its flag set.
- R10: msi_req is high exactly when any of status bits 0 to 3 is 1.
- R11: Without a read, a set change flag stays set, even across further changes of its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_pin | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_pin | input | 1 | Ring-indicator pin, active low, asynchronous |
| dcd_n_pin | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_en | input | 1 | Loopback enable (modem-control bit 4) |
| mc_rts | input | 1 | Modem-control RTS bit, looped to bit 4 |
| mc_dtr | input | 1 | Modem-control DTR bit, looped to bit 5 |
| mc_out1 | input | 1 | Modem-control OUT1 bit, looped to bit 6 |
| mc_out2 | input | 1 | Modem-control OUT2 bit, looped to bit 7 |
| rd_stb | input | 1 | Status register read strobe |
| status_byte | output | 8 | {dcd, ri, cts/dsr levels..., flags}: bits 7:4 levels, bits 3:0 change flags |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
Each pin is toggled on its own in both directions, and the bench confirms that only the matching flag moves. This separates the three either-edge lines from the ring line, whose falling pin edge must leave the flag clear. Repeated toggles without a read show that the flags are sticky. A read timed to meet a fresh detection at the same edge shows that the change is not lost. In loopback, the pins are wiggled while the modem-control bits stay still, which shows the pins are isolated. The control bits are then wiggled to show they drive both the levels and the flags, including the inverted sense of the ring trailing edge.

// File: rtl/msr_pkg.sv
// Package: shared widths, bit positions and reset values for the modem
// status register. Assumes four modem lines in the fixed order CTS, DSR,
// RI, DCD (index 0..3), which is the order software decodes.
package msr_pkg;
    localparam int LINES     = 4;
    localparam int IDX_CTS   = 0;
    localparam int IDX_DSR   = 1;
    localparam int IDX_RI    = 2;
    localparam int IDX_DCD   = 3;
    // Lines whose flag sets only when the active-high level falls
    // (pin trailing edge) instead of on any change.
    localparam logic [LINES-1:0] TRAIL_ONLY = 4'b0100;

    typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/msr_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent (no bus coherency needed) and that the
// reset value matches the idle pin level so release causes no change.
module msr_sync #(
    parameter int WIDTH           = 4,
    parameter int STAGES          = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pin levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
// Module: selects the active-high line levels from either the synchronised
// pins (complemented) or the looped-back modem-control bits.
// Assumes the modem-control bits are already in the clk domain.
module msr_src_sel
    import msr_pkg::*;
(
    input  logic      loop_en,
    input  line_vec_t pin_n_sync,
    input  line_vec_t loop_bits,
    output line_vec_t level
);
    // Loopback replaces every pin with its control bit.
    always_comb begin
        if (loop_en) level = loop_bits;
        else         level = ~pin_n_sync;
    end
endmodule

// File: rtl/msr_delta.sv
// Module: per-line sticky change flags with read-clear. A line listed in
// TRAIL_MASK sets only on a falling active-high level; the others set on
// any change. A detection at the read edge wins over the clear.
module msr_delta #(
    parameter int N = 4,
    parameter logic [N-1:0] TRAIL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    input  logic         rd_stb,
    output logic [N-1:0] prev_q,
    output logic [N-1:0] flag_q
);
    logic [N-1:0] hit;

    // Per-line detector variant chosen by the mask.
    for (genvar i = 0; i < N; i++) begin : g_det
        if (TRAIL_MASK[i]) begin : g_trail
            assign hit[i] = prev_q[i] & ~level[i];
        end else begin : g_any
            assign hit[i] = prev_q[i] ^ level[i];
        end
    end

    // Remember last level; clear is overridden by a fresh hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= level;
            flag_q <= (rd_stb ? '0 : flag_q) | hit;
        end
    end
endmodule

// File: rtl/modem_status_reg.sv
// Module: modem status register top. Synchronises the four active-low
// modem pins, applies loopback, keeps change flags and raises the
// modem-status interrupt request. Assumes rd_stb is one cycle per read.
module modem_status_reg
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n_pin,
    input  logic       dsr_n_pin,
    input  logic       ri_n_pin,
    input  logic       dcd_n_pin,
    input  logic       loop_en,
    input  logic       mc_rts,
    input  logic       mc_dtr,
    input  logic       mc_out1,
    input  logic       mc_out2,
    input  logic       rd_stb,
    output logic [7:0] status_byte,
    output logic       msi_req
);
    line_vec_t pin_n_raw, pin_n_sync, loop_bits, level_w, prev_w, flag_w;

    assign pin_n_raw = {dcd_n_pin, ri_n_pin, dsr_n_pin, cts_n_pin};
    assign loop_bits = {mc_out2, mc_out1, mc_dtr, mc_rts};

    msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_n_raw), .q_sync(pin_n_sync)
    );

    msr_src_sel u_sel (
        .loop_en(loop_en), .pin_n_sync(pin_n_sync),
        .loop_bits(loop_bits), .level(level_w)
    );

    msr_delta #(.N(LINES), .TRAIL_MASK(TRAIL_ONLY)) u_delta (
        .clk(clk), .rst_n(rst_n), .level(level_w), .rd_stb(rd_stb),
        .prev_q(prev_w), .flag_q(flag_w)
    );

    // Status byte: levels in the upper nibble, flags in the lower.
    assign status_byte = {level_w, flag_w};
    assign msi_req     = |flag_w;
endmodule

// File: rtl/modem_status_reg_chk.sv
// Checker: temporal properties of the modem status register, bound to
// the top module. Observes ports plus the level/previous-level nets.
module modem_status_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_en,
    input logic       mc_rts,
    input logic       mc_dtr,
    input logic       mc_out1,
    input logic       mc_out2,
    input logic       rd_stb,
    input logic [7:0] status_byte,
    input logic       msi_req,
    input logic [3:0] lvl,
    input logic [3:0] prv
);
    // R1: reset clears the flags and the request
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (status_byte[3:0] == 4'b0) && !msi_req);

    // R2: a CTS flag rise must come from a CTS level change
    a_r2_cts_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[0]) |-> $past(lvl[0] != prv[0]));

    // R4: a ring flag rise must come from a falling level
    a_r4_ri_trailing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[2]) |-> $past(prv[2] && !lvl[2]));

    // R7: loopback levels follow the control bits
    a_r7_loop_levels: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> status_byte[7:4] == {mc_out2, mc_out1, mc_dtr, mc_rts});

    // R8: a read with no new change leaves all flags clear
    a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && lvl == prv) |=> status_byte[3:0] == 4'b0);

    // R11: without a read, set flags stay set
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (status_byte[3:0] & $past(status_byte[3:0])) == $past(status_byte[3:0]));

    // R10: the request rises only after a detected change
    a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> $past(lvl != prv));
endmodule

bind modem_status_reg modem_status_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
    .mc_rts(mc_rts), .mc_dtr(mc_dtr), .mc_out1(mc_out1), .mc_out2(mc_out2),
    .rd_stb(rd_stb), .status_byte(status_byte), .msi_req(msi_req),
    .lvl(level_w), .prv(prev_w)
);

// File: tb/modem_status_reg_test.sv
// Directed bench: one task per scenario, each checking its own results.
module modem_status_reg_test;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic loop_en = 1'b0, rts = 1'b0, dtr = 1'b0, out1 = 1'b0, out2 = 1'b0;
    logic rd_stb = 1'b0;
    logic [7:0] status_byte;
    logic msi_req;
    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_status_reg uut (
        .clk(clk), .rst_n(rst_n),
        .cts_n_pin(cts_n), .dsr_n_pin(dsr_n), .ri_n_pin(ri_n), .dcd_n_pin(dcd_n),
        .loop_en(loop_en), .mc_rts(rts), .mc_dtr(dtr), .mc_out1(out1), .mc_out2(out2),
        .rd_stb(rd_stb), .status_byte(status_byte), .msi_req(msi_req)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle read; returns the byte seen during the strobe.
    task automatic do_read(output logic [7:0] val);
        rd_stb = 1'b1;
        #1 val = status_byte;
        step(1);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset();
        step(3);
        check("R1 flags in reset", status_byte, 8'h00);
        check("R1 irq in reset", {7'b0, msi_req}, 8'h00);
        rst_n = 1'b1;
        step(4);
        check("R1 after release", status_byte, 8'h00);
    endtask

    task automatic t_cts_dsr_dcd();
        logic [7:0] v;
        cts_n = 1'b0;
        step(2);
        check("R6 cts level after two edges", status_byte, 8'h10);
        step(1);
        check("R2 cts fall sets bit0", status_byte, 8'h11);
        check("R10 irq on flag", {7'b0, msi_req}, 8'h01);
        do_read(v);
        check("R8 read value", v, 8'h11);
        check("R8 cleared after read", status_byte, 8'h10);
        check("R10 irq drops", {7'b0, msi_req}, 8'h00);
        cts_n = 1'b1; step(4);
        check("R2 cts rise sets bit0", status_byte, 8'h01);
        do_read(v);
        dsr_n = 1'b0; step(4);
        check("R3 dsr sets bit1 level bit5", status_byte, 8'h22);
        dsr_n = 1'b1; step(4);
        check("R11 bit1 sticky over second change", status_byte, 8'h02);
        do_read(v);
        dcd_n = 1'b0; step(4);
        check("R5 dcd sets bit3 level bit7", status_byte, 8'h88);
        dcd_n = 1'b1; step(4);
        do_read(v);
        check("R8 cleared", status_byte, 8'h00);
    endtask

    task automatic t_ring();
        logic [7:0] v;
        ri_n = 1'b0; step(4);
        check("R4 ri pin fall leaves bit2 clear", status_byte, 8'h40);
        check("R10 no irq", {7'b0, msi_req}, 8'h00);
        ri_n = 1'b1; step(4);
        check("R4 ri pin rise sets bit2", status_byte, 8'h04);
        do_read(v);
    endtask

    task automatic t_read_collide();
        logic [7:0] v;
        cts_n = 1'b0;
        step(2);
        rd_stb = 1'b1;
        #1 v = status_byte;
        check("R9 read before detect", v, 8'h10);
        step(1);
        rd_stb = 1'b0;
        check("R9 detect at read edge kept", status_byte, 8'h11);
        cts_n = 1'b1; step(4);
        do_read(v);
        check("R8 clear", status_byte, 8'h00);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        loop_en = 1'b1; step(2);
        check("R7 entering loopback no change", status_byte, 8'h00);
        cts_n = 1'b0; dsr_n = 1'b0; ri_n = 1'b0; dcd_n = 1'b0; step(4);
        check("R7 pins ignored in loopback", status_byte, 8'h00);
        rts = 1'b1; step(1);
        check("R7 rts looped to bit4 and bit0", status_byte, 8'h11);
        do_read(v);
        dtr = 1'b1; out2 = 1'b1; step(1);
        check("R7 dtr/out2 looped", status_byte, 8'hBA);
        do_read(v);
        out1 = 1'b1; step(1);
        check("R7 out1 rise no ri flag", status_byte, 8'hF0);
        out1 = 1'b0; step(1);
        check("R7 out1 fall sets ri flag", status_byte, 8'hB4);
        do_read(v);
        rts = 1'b0; dtr = 1'b0; out2 = 1'b0; step(1);
        do_read(v);
        cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1; step(4);
        loop_en = 1'b0; step(2);
        check("R6 back to pins", status_byte, 8'h00);
    endtask

    task automatic t_reset_mid();
        dcd_n = 1'b0; step(4);
        check("R5 flag before reset", status_byte, 8'h88);
        rst_n = 1'b0; step(1);
        check("R1 reset clears flags", {4'b0, status_byte[3:0]}, 8'h00);
        check("R1 reset clears irq", {7'b0, msi_req}, 8'h00);
        dcd_n = 1'b1; step(3);
        rst_n = 1'b1; step(3);
        check("R1 quiet after reset", status_byte, 8'h00);
    endtask

    initial begin
        t_reset();
        t_cts_dsr_dcd();
        t_ring();
        t_read_collide();
        t_loop();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule